// File: doc/BRIEF.md
# Load and Battery Fault Supervisor

This block sits between the channel command register of a six-channel low-side gate predriver and its gate outputs. Every cycle it decides which gates may actually be driven. It watches one short comparator and one open comparator per channel, plus an over-voltage and an under-voltage comparator on the battery rail. From these it produces a live fault vector and an active-low fault flag that can be wire-ORed onto a shared interrupt line.

A short is only meaningful while a channel is driven. An open load is only meaningful while the channel is commanded off. A short has to persist for a programmable number of cycles before it counts. A parameter picks the reaction to a confirmed short:
- Latch the channel off until the serial port sends a clear pulse, or until the command drops.
- Keep retrying with a low-duty PWM for as long as the short lasts.

A battery fault forces every gate off and hides all load faults until the rail recovers.

Top module: `load_fault_supervisor`

## Requirements
- R1: Every comparator input passes through a two-flop synchroniser. A comparator change driven before clock edge k first affects the outputs after edge k+1, and not after edge k.
- R2: Short sensing counts only while the channel's gate is driven. The open comparator is reported only while `cmd_on` of that channel is 0. A short seen with the command off, or an open seen with the command on, leaves the fault vector at 0.
- R3: A short is confirmed only after it has been seen on DEGLITCH consecutive synchronised cycles. A synchronised pulse of DEGLITCH-1 cycles leaves no trace. A short driven before edge k is confirmed at edge k+DEGLITCH+1.
- R4: In latch-off mode (PWM_RETRY=0), a confirmed short forces that gate to 0, sets fault bit i (bits 0..NCH-1 map to channels 0..NCH-1) and pulls `fault_n` low.
- R5: A latched short stays set after the short disappears. It clears on a one-cycle `clr_latch` pulse, or when the channel's command goes to 0.
- R6: In retry mode (PWM_RETRY=1), a confirmed short drives the gate high for PWM_ON cycles out of every PWM_PERIOD cycles while the short lasts, with its fault bit held at 1. The other channels are unaffected.
- R7: In retry mode, once the short is gone, the gate returns to its steady command and the fault bit clears within one PWM period.
- R8: An over-voltage (fault bit NCH+1) or under-voltage (fault bit NCH) condition forces every gate to 0 whatever the commands, and pulls `fault_n` low.
- R9: While a battery fault is present, fault bits 0..NCH-1 read 0. Load reporting and normal gate control resume once the battery condition clears.
- R10: With HAS_UV=0, fault bit NCH is always 0 and the under-voltage input affects no gate.
- R11: `fault_n` is 0 exactly when some bit of `fault_vec` is 1. After reset the fault vector is 0 and each gate follows its command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | NCH | Commanded channel state from the command register, 1 = on |
| short_cmp | input | NCH | Asynchronous drain-high (short) comparator per channel |
| open_cmp | input | NCH | Asynchronous drain-low (open) comparator per channel |
| ov_cmp | input | 1 | Asynchronous battery over-voltage comparator |
| uv_cmp | input | 1 | Asynchronous battery under-voltage comparator |
| clr_latch | input | 1 | One-cycle pulse from the serial port clearing latched shorts |
| gate_en | output | NCH | Actual gate enable per channel |
| fault_vec | output | NCH+2 | Live faults: load bits, then under-voltage, then over-voltage |
| fault_n | output | 1 | Active-low summary fault flag |

## Verification
The embedded assertions check these on every cycle:
- A battery fault always coincides with all gates off and all load bits masked.
- A latched short never leaves its gate driven.
- A retried short is only driven inside the PWM on-window.
- The deglitch counter never passes its limit.

Only the bench's scenarios can show the rest:
- The exact confirmation cycle and the rejection of a pulse one cycle too short.
- The two-edge synchroniser delay.
- The measured PWM duty over whole periods.
- Recovery after a short or a battery fault.
- Each way of clearing a latch.

// File: rtl/load_fault_supervisor.sv
module load_fault_supervisor #(
  parameter int NCH        = 6,
  parameter int DEGLITCH   = 64,
  parameter int PWM_PERIOD = 256,
  parameter int PWM_ON     = 16,
  parameter bit PWM_RETRY  = 1'b0,
  parameter bit HAS_UV     = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   cmd_on,
  input  logic [NCH-1:0]   short_cmp,
  input  logic [NCH-1:0]   open_cmp,
  input  logic             ov_cmp,
  input  logic             uv_cmp,
  input  logic             clr_latch,
  output logic [NCH-1:0]   gate_en,
  output logic [NCH+1:0]   fault_vec,
  output logic             fault_n
);
  localparam int DW = $clog2(DEGLITCH + 1);
  localparam int PW = $clog2(PWM_PERIOD + 1);

  logic [NCH-1:0] sh_m, sh_s, op_m, op_s;
  logic [1:0]     bat_m, bat_s;
  logic           bat_ov, bat_uv, bat_any;
  logic [PW-1:0]  pwm_cnt;
  logic           pwm_phase;
  logic [NCH-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_m  <= '0;
      sh_s  <= '0;
      op_m  <= '0;
      op_s  <= '0;
      bat_m <= '0;
      bat_s <= '0;
    end else begin
      sh_m  <= short_cmp;
      sh_s  <= sh_m;
      op_m  <= open_cmp;
      op_s  <= op_m;
      bat_m <= {ov_cmp, uv_cmp};
      bat_s <= bat_m;
    end
  end

  assign bat_ov  = bat_s[1];
  assign bat_uv  = HAS_UV ? bat_s[0] : 1'b0;
  assign bat_any = bat_ov | bat_uv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_cnt <= '0;
    else if (pwm_cnt == PW'(PWM_PERIOD - 1)) pwm_cnt <= '0;
    else pwm_cnt <= pwm_cnt + 1'b1;
  end

  assign pwm_phase = (pwm_cnt < PW'(PWM_ON));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] cnt;
    logic          sense, confirm, drop;

    assign sense   = gate_en[i] & sh_s[i];
    assign confirm = sense & ~hit[i] & (cnt == DW'(DEGLITCH - 1));
    assign drop    = ~cmd_on[i] | clr_latch |
                     (PWM_RETRY & (bat_any | (hit[i] & gate_en[i] & ~sh_s[i])));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt    <= '0;
        hit[i] <= 1'b0;
      end else begin
        if (!sense || hit[i] || confirm) cnt <= '0;
        else cnt <= cnt + 1'b1;
        if (drop) hit[i] <= 1'b0;
        else if (confirm) hit[i] <= 1'b1;
      end
    end

    assign gate_en[i]   = cmd_on[i] & ~bat_any & (~hit[i] | (PWM_RETRY & pwm_phase));
    assign fault_vec[i] = ~bat_any & (hit[i] | (~cmd_on[i] & op_s[i]));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < DW'(DEGLITCH)) else $error("deglitch count overrun"); // R3

    if (!PWM_RETRY) begin : g_latch
      AST_LATCH_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vec[i] && cmd_on[i]) |-> !gate_en[i]) else $error("latched short still driven"); // R4
    end else begin : g_pwm
      AST_PWM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[i] && !pwm_phase) |-> !gate_en[i]) else $error("retry outside on-window"); // R6
    end
  end

  assign fault_vec[NCH]   = bat_uv;
  assign fault_vec[NCH+1] = bat_ov;
  assign fault_n          = ~|fault_vec;

  AST_BAT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vec[NCH+1] || fault_vec[NCH]) |-> (gate_en == '0)) else $error("gate on in battery fault"); // R8
  AST_BAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vec[NCH+1] || fault_vec[NCH]) |-> (fault_vec[NCH-1:0] == '0)) else $error("load fault unmasked"); // R9
  AST_FLAG_ON_OV: assert property (@(posedge clk) disable iff (!rst_n)
    fault_vec[NCH+1] |-> !fault_n) else $error("flag missing"); // R11

  if (!HAS_UV) begin : g_no_uv
    AST_NO_UV_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_vec[NCH]) else $error("uv bit in variant without uv"); // R10
  end
endmodule

// File: tb/tb_load_fault_supervisor.sv
module tb_load_fault_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 8;
  localparam int P  = 16;
  localparam int ON = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cmd_on = '0, short_cmp = '0, open_cmp = '0;
  logic       ov_cmp = 1'b0, uv_cmp = 1'b0, clr_latch = 1'b0;
  logic [5:0] gate, gate_p;
  logic [7:0] flt, flt_p;
  logic       fn, fn_p;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_fault_supervisor #(.NCH(6), .DEGLITCH(D), .PWM_PERIOD(P), .PWM_ON(ON),
    .PWM_RETRY(1'b0), .HAS_UV(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .short_cmp(short_cmp), .open_cmp(open_cmp),
    .ov_cmp(ov_cmp), .uv_cmp(uv_cmp), .clr_latch(clr_latch),
    .gate_en(gate), .fault_vec(flt), .fault_n(fn));

  load_fault_supervisor #(.NCH(6), .DEGLITCH(D), .PWM_PERIOD(P), .PWM_ON(ON),
    .PWM_RETRY(1'b1), .HAS_UV(1'b0)) dut_pwm (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .short_cmp(short_cmp), .open_cmp(open_cmp),
    .ov_cmp(ov_cmp), .uv_cmp(uv_cmp), .clr_latch(clr_latch),
    .gate_en(gate_p), .fault_vec(flt_p), .fault_n(fn_p));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [5:0] exp_gate(logic [5:0] c, logic [5:0] s, logic ov, logic uv);
    return (ov | uv) ? 6'h00 : (c & ~s);
  endfunction

  function automatic logic [7:0] exp_flt(logic [5:0] c, logic [5:0] s, logic [5:0] o,
                                         logic ov, logic uv);
    if (ov | uv) return {ov, uv, 6'h00};
    return {2'b00, (c & s) | (~c & o)};
  endfunction

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int ones, fhold;
    void'($urandom(32'd4711));
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    chk("R11 reset gate", gate, 6'h00);
    chk("R11 reset vec", flt, 8'h00);
    chk("R11 reset flag", fn, 1'b1);

    cmd_on = 6'h3F;
    cycles(1);
    chk("R11 gate follows cmd", gate, 6'h3F);
    ov_cmp = 1'b1;
    cycles(1);
    chk("R1 ov not yet seen", gate, 6'h3F);
    cycles(1);
    chk("R1 R8 ov gates off", gate, 6'h00);
    chk("R8 ov bit", flt, 8'h80);
    chk("R8 flag low", fn, 1'b0);
    ov_cmp = 1'b0;
    cycles(2);
    chk("R9 gates resume", gate, 6'h3F);
    chk("R11 flag released", fn, 1'b1);
    uv_cmp = 1'b1;
    cycles(3);
    chk("R8 uv gates off", gate, 6'h00);
    chk("R8 uv bit", flt, 8'h40);
    chk("R10 uv no gate effect", gate_p, 6'h3F);
    chk("R10 uv bit zero", flt_p, 8'h00);
    uv_cmp = 1'b0;
    cycles(3);

    cmd_on = 6'h3E; open_cmp = 6'h01;
    cycles(3);
    chk("R2 open when off", flt, 8'h01);
    open_cmp = 6'h03;
    cycles(3);
    chk("R2 open ignored when on", flt, 8'h01);
    ov_cmp = 1'b1;
    cycles(3);
    chk("R9 load bits masked", flt, 8'h80);
    ov_cmp = 1'b0;
    cycles(3);
    chk("R9 load reporting resumes", flt, 8'h01);
    open_cmp = 6'h00; cmd_on = 6'h3F;
    cycles(3);

    short_cmp = 6'h04;
    cycles(D + 1);
    chk("R3 not yet confirmed", flt, 8'h00);
    chk("R3 gate still on", gate, 6'h3F);
    cycles(1);
    chk("R3 R4 short bit", flt, 8'h04);
    chk("R4 gate off", gate, 6'h3B);
    chk("R4 flag low", fn, 1'b0);
    short_cmp = 6'h00;
    cycles(5);
    chk("R5 latch holds", flt, 8'h04);
    clr_latch = 1'b1;
    cycles(1);
    clr_latch = 1'b0;
    chk("R5 clear pulse vec", flt, 8'h00);
    chk("R5 clear pulse gate", gate, 6'h3F);

    short_cmp = 6'h01;
    cycles(D + 4);
    short_cmp = 6'h00;
    cycles(4);
    chk("R5 latched ch0", flt, 8'h01);
    cmd_on = 6'h3E;
    cycles(1);
    cmd_on = 6'h3F;
    cycles(1);
    chk("R5 cmd off clears vec", flt, 8'h00);
    chk("R5 cmd off clears gate", gate, 6'h3F);

    short_cmp = 6'h08;
    cycles(D - 1);
    short_cmp = 6'h00;
    cycles(6);
    chk("R3 short pulse rejected", flt, 8'h00);
    chk("R3 short pulse gate", gate, 6'h3F);

    cmd_on = 6'h2F; short_cmp = 6'h10;
    cycles(2 * D);
    chk("R2 short ignored when off", flt, 8'h00);
    short_cmp = 6'h00; cmd_on = 6'h3F;
    clr_latch = 1'b1;
    cycles(1);
    clr_latch = 1'b0;
    cycles(3);

    short_cmp = 6'h20;
    cycles(D + 4);
    ones = 0; fhold = 0;
    for (int k = 0; k < 2 * P; k++) begin
      if (gate_p[5]) ones++;
      if (flt_p[5]) fhold++;
      if (gate_p[4:0] !== 5'h1F) begin
        n_fail++;
        $display("FAIL R6 other channels actual=%h expected=%h", gate_p[4:0], 5'h1F);
      end
      cycles(1);
    end
    chk("R6 pwm duty", ones, 2 * ON);
    chk("R6 fault held", fhold, 2 * P);
    short_cmp = 6'h00;
    cycles(P + 4);
    chk("R7 pwm gate recovered", gate_p, 6'h3F);
    chk("R7 pwm bit cleared", flt_p, 8'h00);

    for (int it = 0; it < 40; it++) begin
      logic [5:0] c, s, o;
      logic ov, uv;
      cmd_on = 6'h00; short_cmp = 6'h00; open_cmp = 6'h00;
      ov_cmp = 1'b0; uv_cmp = 1'b0; clr_latch = 1'b1;
      cycles(1);
      clr_latch = 1'b0;
      cycles(3);
      c = 6'($urandom); s = 6'($urandom); o = 6'($urandom);
      ov = ($urandom % 4) == 0; uv = ($urandom % 4) == 0;
      cmd_on = c; short_cmp = s; open_cmp = o; ov_cmp = ov; uv_cmp = uv;
      cycles(D + 6);
      chk("R4 R8 random gate", gate, exp_gate(c, s, ov, uv));
      chk("R2 R9 random vec", flt, exp_flt(c, s, o, ov, uv));
      chk("R11 random flag", fn, exp_flt(c, s, o, ov, uv) == 8'h00);
      chk("R10 random variant bits", flt_p[7:6], {ov, 1'b0});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule